// File: doc/BRIEF.md
# Auxiliary Register Address Generator

This block produces operand addresses for a DSP-style datapath. It keeps eight 32-bit pointer registers, two 32-bit index registers, a 32-bit circular block-length register and a data-page register. Two address lanes run in parallel. Each lane can accept one request per cycle and returns a 24-bit effective address one clock later.

A request is either a direct address or an indirect one. A direct address joins the low byte of the page register to a 16-bit word taken from the instruction. An indirect address uses a selected pointer register. It can leave that register unchanged, modify it before the access, or modify it after the access, either linearly or with circular wrap. Each modifying lane writes the updated pointer back on the same edge that registers its address, so the next request on either lane sees the new value.

A host port loads any of the twelve registers. The block flags a cycle in which both lanes name the same pointer register.

Top module: `arx_agen`

## Requirements
- R1: A synchronous active-high reset clears every register, both address-valid outputs and the clash flag to zero.
- R2: Mode 0 (direct): the address is {page[7:0], word[15:0]}. It appears on the lane's address output one clock after the request, with the lane's valid bit set.
- R3: Modes 4 (post-add) and 5 (post-subtract): the address is the pointer's old value. The pointer then becomes old plus the step (mode 4) or old minus the step (mode 5).
- R4: Modes 2 (pre-add) and 3 (pre-subtract): the address and the new pointer value are both old plus the step (mode 2) or old minus the step (mode 3).
- R5: Mode 1, and the unused codes 6 and 7, give the pointer's value as the address and leave the pointer unchanged.
- R6: The step select takes these values: 0 gives a step of one, 1 gives the 8-bit unsigned displacement, 2 gives index register 0, and 3 gives index register 1.
- R7: If the circular flag is set on a post mode, the signed sum s is corrected. When 0 <= s < L it is kept. When s >= L it becomes s - L, so s = L gives 0. When s < 0 it becomes s + L. L is the block-length register. The circular flag has no effect in other modes.
- R8: Both lanes serve requests in the same cycle independently when they name different pointers.
- R9: If both lanes carry indirect requests (modes 1 to 7) naming the same pointer, the clash output is high in the following cycle. When both lanes modify that pointer, lane 1's value is the one kept.
- R10: The host write select is encoded as follows: 0 to 7 select a pointer register, 8 and 9 select the index registers, 10 selects the block length and 11 selects the page. If a lane writes a pointer back in the same cycle the host writes it, the lane's value is kept.
- R11: Addresses are the low 24 bits of the computed value. Pointer registers and the circular comparison use all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Host register write strobe |
| hw_sel | input | 4 | Host register select (R10 encoding) |
| hw_data | input | 32 | Host write data |
| rq_vld | input | 2 | Request valid, one bit per lane |
| rq_mode | input | 2x3 | Addressing mode per lane |
| rq_ar | input | 2x3 | Pointer register select per lane |
| rq_step | input | 2x2 | Step source per lane |
| rq_disp | input | 2x8 | Unsigned displacement per lane |
| rq_circ | input | 2 | Circular-wrap flag per lane |
| rq_word | input | 2x16 | Instruction word low bits per lane |
| ea_vld | output | 2 | Registered address valid per lane |
| ea | output | 2x24 | Registered effective address per lane |
| clash | output | 1 | Both lanes named one pointer in the previous cycle |

## Verification
The circular-range property applies only when the pointer starts inside the buffer and the step is no larger than the block length. Outside those conditions the correction of a single pass need not land inside the buffer. The bench therefore loads pointers below the length before every circular sequence. The properties that check an unchanged pointer or a loaded length assume that no other lane and no host write touches the register in the same cycle. Only the directed clash and host-priority scenarios break that assumption, and they use pointers that those properties do not watch.

// File: rtl/arx_agen_pkg.sv
package arx_agen_pkg;
  parameter int DW    = 32;
  parameter int AW    = 24;
  parameter int NAR   = 8;
  parameter int NLANE = 2;
  parameter int DISPW = 8;
  parameter int WORDW = 16;
  parameter int PGW   = 8;
  localparam int ARW  = $clog2(NAR);
  localparam int SELW = 4;

  localparam logic [SELW-1:0] SEL_IDX0 = 4'd8;
  localparam logic [SELW-1:0] SEL_IDX1 = 4'd9;
  localparam logic [SELW-1:0] SEL_BLK  = 4'd10;
  localparam logic [SELW-1:0] SEL_PAGE = 4'd11;

  typedef enum logic [2:0] {
    M_DIRECT = 3'd0, M_PLAIN = 3'd1, M_PRE_ADD = 3'd2, M_PRE_SUB = 3'd3,
    M_POST_ADD = 3'd4, M_POST_SUB = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    S_ONE = 2'd0, S_DISP = 2'd1, S_IDX0 = 2'd2, S_IDX1 = 2'd3
  } step_e;
endpackage

// File: rtl/arx_regfile.sv
module arx_regfile
  import arx_agen_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hw_en,
  input  logic [SELW-1:0]            hw_sel,
  input  logic [DW-1:0]              hw_data,
  input  logic [NLANE-1:0]           wb_en,
  input  logic [NLANE-1:0][ARW-1:0]  wb_sel,
  input  logic [NLANE-1:0][DW-1:0]   wb_val,
  output logic [NAR-1:0][DW-1:0]     ar_q,
  output logic [DW-1:0]              idx0_q,
  output logic [DW-1:0]              idx1_q,
  output logic [DW-1:0]              blk_q,
  output logic [DW-1:0]              page_q
);
  // Pointer bank: host write first, then lanes in ascending order so the
  // highest lane's write-back is the one that sticks.
  always_ff @(posedge clk) begin
    if (rst) begin
      ar_q <= '0;
    end else begin
      for (int r = 0; r < NAR; r++) begin
        if (hw_en && hw_sel == SELW'(r)) ar_q[r] <= hw_data;
        for (int l = 0; l < NLANE; l++) begin
          if (wb_en[l] && wb_sel[l] == ARW'(r)) ar_q[r] <= wb_val[l];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx0_q <= '0;
      idx1_q <= '0;
      blk_q  <= '0;
      page_q <= '0;
    end else if (hw_en) begin
      if (hw_sel == SEL_IDX0) idx0_q <= hw_data;
      if (hw_sel == SEL_IDX1) idx1_q <= hw_data;
      if (hw_sel == SEL_BLK)  blk_q  <= hw_data;
      if (hw_sel == SEL_PAGE) page_q <= hw_data;
    end
  end
endmodule

// File: rtl/arx_lane.sv
module arx_lane
  import arx_agen_pkg::*;
(
  input  logic                    vld,
  input  logic [2:0]              mode,
  input  logic [ARW-1:0]          arsel,
  input  logic [1:0]              stepsel,
  input  logic [DISPW-1:0]        disp,
  input  logic                    circ,
  input  logic [WORDW-1:0]        word,
  input  logic [NAR-1:0][DW-1:0]  ar_all,
  input  logic [DW-1:0]           idx0,
  input  logic [DW-1:0]           idx1,
  input  logic [DW-1:0]           blk,
  input  logic [DW-1:0]           page,
  output logic [AW-1:0]           addr,
  output logic                    wb_en,
  output logic [DW-1:0]           wb_val
);
  localparam int SW = DW + 2;

  logic [DW-1:0]        base, step, lin_add, lin_sub, circ_val;
  logic signed [SW-1:0] sum, blk_s;

  always_comb begin
    unique case (step_e'(stepsel))
      S_ONE:   step = DW'(1);
      S_DISP:  step = DW'(disp);
      S_IDX0:  step = idx0;
      default: step = idx1;
    endcase
  end

  assign base    = ar_all[arsel];
  assign lin_add = base + step;
  assign lin_sub = base - step;

  // Single-pass circular correction on the full-width pointer.
  always_comb begin
    blk_s = $signed({2'b00, blk});
    if (mode == M_POST_SUB) sum = $signed({2'b00, base}) - $signed({2'b00, step});
    else                    sum = $signed({2'b00, base}) + $signed({2'b00, step});
    if (sum < 0)           circ_val = DW'(sum + blk_s);
    else if (sum >= blk_s) circ_val = DW'(sum - blk_s);
    else                   circ_val = DW'(sum);
  end

  always_comb begin
    addr   = base[AW-1:0];
    wb_en  = 1'b0;
    wb_val = base;
    case (mode)
      M_DIRECT:   addr = AW'({page[PGW-1:0], word});
      M_PRE_ADD:  begin addr = lin_add[AW-1:0]; wb_en = vld; wb_val = lin_add; end
      M_PRE_SUB:  begin addr = lin_sub[AW-1:0]; wb_en = vld; wb_val = lin_sub; end
      M_POST_ADD: begin wb_en = vld; wb_val = circ ? circ_val : lin_add; end
      M_POST_SUB: begin wb_en = vld; wb_val = circ ? circ_val : lin_sub; end
      default:    ;
    endcase
  end
endmodule

// File: rtl/arx_agen.sv
module arx_agen
  import arx_agen_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          hw_en,
  input  logic [SELW-1:0]               hw_sel,
  input  logic [DW-1:0]                 hw_data,
  input  logic [NLANE-1:0]              rq_vld,
  input  logic [NLANE-1:0][2:0]         rq_mode,
  input  logic [NLANE-1:0][ARW-1:0]     rq_ar,
  input  logic [NLANE-1:0][1:0]         rq_step,
  input  logic [NLANE-1:0][DISPW-1:0]   rq_disp,
  input  logic [NLANE-1:0]              rq_circ,
  input  logic [NLANE-1:0][WORDW-1:0]   rq_word,
  output logic [NLANE-1:0]              ea_vld,
  output logic [NLANE-1:0][AW-1:0]      ea,
  output logic                          clash
);
  logic [NAR-1:0][DW-1:0]     ar_cur;
  logic [DW-1:0]              idx0_cur, idx1_cur, blk_cur, page_cur;
  logic [NLANE-1:0]           wb_en;
  logic [NLANE-1:0][DW-1:0]   wb_val;
  logic [NLANE-1:0][AW-1:0]   addr_c;
  logic                       clash_c;

  arx_regfile u_rf (
    .clk(clk), .rst(rst), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
    .wb_en(wb_en), .wb_sel(rq_ar), .wb_val(wb_val),
    .ar_q(ar_cur), .idx0_q(idx0_cur), .idx1_q(idx1_cur),
    .blk_q(blk_cur), .page_q(page_cur)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    arx_lane u_lane (
      .vld(rq_vld[g]), .mode(rq_mode[g]), .arsel(rq_ar[g]),
      .stepsel(rq_step[g]), .disp(rq_disp[g]), .circ(rq_circ[g]),
      .word(rq_word[g]), .ar_all(ar_cur), .idx0(idx0_cur), .idx1(idx1_cur),
      .blk(blk_cur), .page(page_cur),
      .addr(addr_c[g]), .wb_en(wb_en[g]), .wb_val(wb_val[g])
    );
  end

  assign clash_c = &rq_vld && (rq_mode[0] != M_DIRECT) &&
                   (rq_mode[1] != M_DIRECT) && (rq_ar[0] == rq_ar[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_vld <= '0;
      ea     <= '0;
      clash  <= 1'b0;
    end else begin
      ea_vld <= rq_vld;
      clash  <= clash_c;
      for (int l = 0; l < NLANE; l++) if (rq_vld[l]) ea[l] <= addr_c[l];
    end
  end
endmodule

// File: rtl/arx_agen_chk.sv
module arx_agen_chk
  import arx_agen_pkg::*;
(
  input logic                        clk,
  input logic                        rst,
  input logic                        hw_en,
  input logic [SELW-1:0]             hw_sel,
  input logic [DW-1:0]               hw_data,
  input logic [NLANE-1:0]            rq_vld,
  input logic [NLANE-1:0][2:0]       rq_mode,
  input logic [NLANE-1:0][ARW-1:0]   rq_ar,
  input logic [NLANE-1:0][1:0]       rq_step,
  input logic [NLANE-1:0][DISPW-1:0] rq_disp,
  input logic [NLANE-1:0]            rq_circ,
  input logic [NLANE-1:0][WORDW-1:0] rq_word,
  input logic [NLANE-1:0]            ea_vld,
  input logic [NLANE-1:0][AW-1:0]    ea,
  input logic                        clash,
  input logic [NAR-1:0][DW-1:0]      ar_cur,
  input logic [DW-1:0]               blk_cur
);
  logic [NLANE-1:0][DW-1:0] sel_val;
  logic                     same_ptr;
  assign same_ptr = &rq_vld && rq_mode[0] != 3'd0 && rq_mode[1] != 3'd0 &&
                    rq_ar[0] == rq_ar[1];

  for (genvar i = 0; i < 2; i++) begin : g_chk
    localparam int O = 1 - i;
    assign sel_val[i] = ar_cur[rq_ar[i]];

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      rq_vld[i] |=> ea_vld[i]);                                                   // R2
    AST_DIRECT_WORD: assert property (@(posedge clk) disable iff (rst)
      rq_vld[i] && rq_mode[i] == 3'd0 |=> ea[i][WORDW-1:0] == $past(rq_word[i]));  // R2
    AST_POST_OLD_ADDR: assert property (@(posedge clk) disable iff (rst)
      rq_vld[i] && (rq_mode[i] == 3'd4 || rq_mode[i] == 3'd5)
      |=> ea[i] == $past(sel_val[i][AW-1:0]));                                    // R3
    AST_PLAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
      rq_vld[i] && rq_mode[i] == 3'd1 && !rq_vld[O] && !hw_en
      |=> ar_cur[$past(rq_ar[i])] == $past(sel_val[i]));                          // R5
    AST_CIRC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
      rq_vld[i] && rq_circ[i] && (rq_mode[i] == 3'd4 || rq_mode[i] == 3'd5) &&
      !rq_vld[O] && blk_cur != '0 && sel_val[i] < blk_cur &&
      (rq_step[i] == 2'd0 || (rq_step[i] == 2'd1 && DW'(rq_disp[i]) <= blk_cur))
      |=> ar_cur[$past(rq_ar[i])] < $past(blk_cur));                              // R7
  end

  AST_CLASH_RAISED: assert property (@(posedge clk) disable iff (rst)
    same_ptr |=> clash);                                                          // R9
  AST_CLASH_QUIET: assert property (@(posedge clk) disable iff (rst)
    !same_ptr |=> !clash);                                                        // R9
  AST_BLK_LOADS: assert property (@(posedge clk) disable iff (rst)
    hw_en && hw_sel == SEL_BLK |=> blk_cur == $past(hw_data));                    // R10
endmodule

bind arx_agen arx_agen_chk u_chk (
  .clk(clk), .rst(rst), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
  .rq_vld(rq_vld), .rq_mode(rq_mode), .rq_ar(rq_ar), .rq_step(rq_step),
  .rq_disp(rq_disp), .rq_circ(rq_circ), .rq_word(rq_word),
  .ea_vld(ea_vld), .ea(ea), .clash(clash), .ar_cur(ar_cur), .blk_cur(blk_cur)
);

// File: tb/arx_agen_tb.sv
module arx_agen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hw_en = 1'b0;
  logic [3:0] hw_sel = '0;
  logic [31:0] hw_data = '0;
  logic [1:0] rq_vld = '0;
  logic [1:0][2:0] rq_mode = '0;
  logic [1:0][2:0] rq_ar = '0;
  logic [1:0][1:0] rq_step = '0;
  logic [1:0][7:0] rq_disp = '0;
  logic [1:0] rq_circ = '0;
  logic [1:0][15:0] rq_word = '0;
  logic [1:0] ea_vld;
  logic [1:0][23:0] ea;
  logic clash;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  arx_agen u_dut (
    .clk(clk), .rst(rst), .hw_en(hw_en), .hw_sel(hw_sel), .hw_data(hw_data),
    .rq_vld(rq_vld), .rq_mode(rq_mode), .rq_ar(rq_ar), .rq_step(rq_step),
    .rq_disp(rq_disp), .rq_circ(rq_circ), .rq_word(rq_word),
    .ea_vld(ea_vld), .ea(ea), .clash(clash)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [3:0] sel, logic [31:0] d);
    @(negedge clk);
    hw_en = 1'b1; hw_sel = sel; hw_data = d;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  task automatic set_lane(int l, logic [2:0] m, logic [2:0] a, logic [1:0] s,
                          logic [7:0] d, logic c, logic [15:0] w);
    rq_vld[l] = 1'b1; rq_mode[l] = m; rq_ar[l] = a; rq_step[l] = s;
    rq_disp[l] = d; rq_circ[l] = c; rq_word[l] = w;
  endtask

  task automatic one(logic [2:0] m, logic [2:0] a, logic [1:0] s, logic [7:0] d,
                     logic c, logic [15:0] w, output logic [23:0] r);
    @(negedge clk);
    set_lane(0, m, a, s, d, c, w);
    @(posedge clk); #1;
    r = ea[0];
    rq_vld = '0;
  endtask

  task automatic peek(logic [2:0] a, output logic [23:0] r);
    one(3'd1, a, 2'd0, 8'd0, 1'b0, 16'd0, r);
  endtask

  task automatic t_reset();
    logic [23:0] r;
    chk("R1 ea_vld after reset", 32'(ea_vld), 0);
    chk("R1 clash after reset", 32'(clash), 0);
    peek(3'd3, r);
    chk("R1 pointer cleared", 32'(r), 0);
  endtask

  task automatic t_direct();
    logic [23:0] r;
    hwr(4'd11, 32'h1234_56AB);
    one(3'd0, 3'd0, 2'd0, 8'd0, 1'b0, 16'h9805, r);
    chk("R2 direct address", 32'(r), 32'hAB9805);
    chk("R2 valid", 32'(ea_vld[0]), 1);
  endtask

  task automatic t_post();
    logic [23:0] r;
    hwr(4'd0, 32'h100);
    one(3'd4, 3'd0, 2'd0, 8'd0, 1'b0, 16'd0, r);
    chk("R3 post-add uses old value", 32'(r), 32'h100);
    peek(3'd0, r);
    chk("R3 R6 post-add by one", 32'(r), 32'h101);
    one(3'd5, 3'd0, 2'd1, 8'd5, 1'b0, 16'd0, r);
    chk("R3 post-sub uses old value", 32'(r), 32'h101);
    peek(3'd0, r);
    chk("R3 R6 post-sub by displacement", 32'(r), 32'hFC);
  endtask

  task automatic t_pre();
    logic [23:0] r;
    hwr(4'd1, 32'h200);
    hwr(4'd8, 32'h10);
    hwr(4'd9, 32'h3);
    one(3'd2, 3'd1, 2'd2, 8'd0, 1'b0, 16'd0, r);
    chk("R4 R6 pre-add index0 address", 32'(r), 32'h210);
    peek(3'd1, r);
    chk("R4 pre-add written back", 32'(r), 32'h210);
    one(3'd3, 3'd1, 2'd3, 8'd0, 1'b0, 16'd0, r);
    chk("R4 R6 pre-sub index1 address", 32'(r), 32'h20D);
  endtask

  task automatic t_plain();
    logic [23:0] r;
    hwr(4'd2, 32'h55);
    one(3'd1, 3'd2, 2'd1, 8'd9, 1'b1, 16'd0, r);
    chk("R5 plain address", 32'(r), 32'h55);
    one(3'd7, 3'd2, 2'd0, 8'd0, 1'b0, 16'd0, r);
    chk("R5 code 7 acts as plain", 32'(r), 32'h55);
    peek(3'd2, r);
    chk("R5 R7 pointer unchanged", 32'(r), 32'h55);
  endtask

  task automatic t_circ();
    logic [23:0] r;
    hwr(4'd10, 32'd6);
    hwr(4'd3, 32'd0);
    one(3'd4, 3'd3, 2'd1, 8'd4, 1'b1, 16'd0, r);
    chk("R7 circ first access", 32'(r), 0);
    one(3'd4, 3'd3, 2'd1, 8'd5, 1'b1, 16'd0, r);
    chk("R7 circ 0+4", 32'(r), 4);
    peek(3'd3, r);
    chk("R7 circ 4+5 wraps to 3", 32'(r), 3);
    one(3'd4, 3'd3, 2'd1, 8'd3, 1'b1, 16'd0, r);
    peek(3'd3, r);
    chk("R7 circ sum equals length gives 0", 32'(r), 0);
    one(3'd5, 3'd3, 2'd1, 8'd2, 1'b1, 16'd0, r);
    peek(3'd3, r);
    chk("R7 circ below zero adds length", 32'(r), 4);
  endtask

  task automatic t_trunc();
    logic [23:0] r;
    hwr(4'd5, 32'hAB12_3456);
    peek(3'd5, r);
    chk("R11 address truncated", 32'(r), 32'h123456);
    hwr(4'd10, 32'h0100_0010);
    hwr(4'd5, 32'h0100_0008);
    one(3'd4, 3'd5, 2'd1, 8'd8, 1'b1, 16'd0, r);
    chk("R11 post address low bits", 32'(r), 32'h000008);
    peek(3'd5, r);
    chk("R11 full-width wrap to 0", 32'(r), 0);
  endtask

  task automatic t_dual();
    logic [23:0] r;
    hwr(4'd4, 32'h40);
    hwr(4'd5, 32'h80);
    @(negedge clk);
    set_lane(0, 3'd4, 3'd4, 2'd0, 8'd0, 1'b0, 16'd0);
    set_lane(1, 3'd4, 3'd5, 2'd0, 8'd0, 1'b0, 16'd0);
    @(posedge clk); #1;
    chk("R8 lane0 address", 32'(ea[0]), 32'h40);
    chk("R8 lane1 address", 32'(ea[1]), 32'h80);
    chk("R8 R9 no clash", 32'(clash), 0);
    rq_vld = '0;
    peek(3'd4, r);
    chk("R8 lane0 update", 32'(r), 32'h41);
    peek(3'd5, r);
    chk("R8 lane1 update", 32'(r), 32'h81);
  endtask

  task automatic t_clash();
    logic [23:0] r;
    hwr(4'd6, 32'h10);
    @(negedge clk);
    set_lane(0, 3'd4, 3'd6, 2'd1, 8'd1, 1'b0, 16'd0);
    set_lane(1, 3'd4, 3'd6, 2'd1, 8'd8, 1'b0, 16'd0);
    @(posedge clk); #1;
    chk("R9 clash raised", 32'(clash), 1);
    rq_vld = '0;
    peek(3'd6, r);
    chk("R9 lane1 write wins", 32'(r), 32'h18);
    chk("R9 clash drops", 32'(clash), 0);
  endtask

  task automatic t_host_pri();
    logic [23:0] r;
    hwr(4'd7, 32'h20);
    @(negedge clk);
    hw_en = 1'b1; hw_sel = 4'd7; hw_data = 32'h999;
    set_lane(0, 3'd4, 3'd7, 2'd0, 8'd0, 1'b0, 16'd0);
    @(posedge clk); #1;
    hw_en = 1'b0; rq_vld = '0;
    peek(3'd7, r);
    chk("R10 lane beats host", 32'(r), 32'h21);
    hwr(4'd7, 32'h777);
    peek(3'd7, r);
    chk("R10 host load pointer", 32'(r), 32'h777);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_direct();
    t_post();
    t_pre();
    t_plain();
    t_circ();
    t_trunc();
    t_dual();
    t_clash();
    t_host_pri();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule